// File: doc/BRIEF.md
# Serial Byte Receiver with Break Wake-Up

This block receives asynchronous serial bytes in the usual one-start, eight-data, one-stop format, with no parity. An external divider supplies a tick at sixteen times the bit rate. Each bit is sampled near its middle. The finished byte is loaded into a holding register, and a receive-interrupt flag is raised. Software clears the flag with a read strobe. A receiver-idle output tells software when no byte is in flight.

Software can arm a wake-up mode by pulsing the wake-set input while the receiver is idle. While armed, start-bit detection is switched off. The receiver then ignores the framing of whatever the line carries, which is usually a long all-zero break. The first falling edge raises the interrupt and loads a dummy zero into the data register. The rising edge that ends the break disarms the mode by itself, and ordinary reception resumes.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset the interrupt flag, framing flag, wake-enable and data register are all 0, and the receiver-idle output is 1.
- R2: With wake-enable clear, a frame is a low start bit, then eight data bits with the least significant bit first, then a stop bit. Each bit lasts 16 ticks. When the frame completes, the data bits are loaded into the data register and the interrupt flag is set.
- R3: The framing flag is loaded with 1 when the stop bit is sampled low, and with 0 when it is sampled high.
- R4: A one-cycle read strobe clears the interrupt flag on the following cycle, unless a new byte or wake event sets it in that same cycle.
- R5: The receiver-idle output is 0 from start-bit detection until the stop bit has been sampled, and 1 at all other times.
- R6: A wake-set pulse while receiver-idle is 1 makes wake-enable read 1 from the next cycle. A wake-set pulse during a reception is ignored.
- R7: While wake-enable is 1, no start bit is detected. A line held low for any length produces no byte and no further interrupt, and receiver-idle stays 1.
- R8: The first falling edge on the line while wake-enable is armed sets the interrupt flag, loads 0x00 into the data register and clears the framing flag.
- R9: The first rising edge after that wake event clears wake-enable. The next frame is then received normally.
- R10: A low pulse that is high again when the middle of the start bit is sampled is dropped. It produces no interrupt, and receiver-idle returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, asynchronous, idles high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rd_i | input | 1 | Read strobe for the data register; clears the interrupt |
| wake_set_i | input | 1 | Pulse to arm wake-up mode |
| rd_data_o | output | 8 | Received byte, or 0x00 after a wake event |
| irq_o | output | 1 | Receive-interrupt flag |
| ferr_o | output | 1 | Framing flag for the last byte |
| idle_o | output | 1 | 1 when no reception is in progress |
| wake_o | output | 1 | Wake-enable readback |

## Verification
The hardest state to reach is a long break held while wake-up is armed. It has to be shown that nothing fires: the line stays low for twelve bit times, yet no start bit is taken and no second interrupt appears. The bench reaches it in stages. It arms the mode during an idle gap, lowers the line and clears the first interrupt with a read, then holds the line low. At the end it checks that the interrupt is still clear and that wake-enable is still set. Only then does it release the line and send a normal byte. A second hard case is a wake-set pulse in the middle of a frame. The bench injects this pulse from inside the driver during a data bit.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_START = 2'd1,
      FR_DATA  = 2'd2,
      FR_STOP  = 2'd3
   } fr_state_t;
endpackage

// File: rtl/uwr_sync.sv
// Multi-stage line synchronizer with edge detection on the resynchronized level.
module uwr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic fall_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain;
   logic              level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= line_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b1;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign fall_o  = level_q & ~chain[STAGES-1];
   assign rise_o  = ~level_q & chain[STAGES-1];
endmodule

// File: rtl/uwr_frame.sv
// Start/data/stop framer, mid-bit sampling on an oversampling tick.
module uwr_frame
   import uwr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              fall_i,
   input  logic              hold_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              stop_o
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W);
   localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] FULL = CW'(OVS - 1);
   localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

   fr_state_t         state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     idx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FR_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         done_o <= 1'b0;
         stop_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            FR_IDLE: begin
               if (fall_i && !hold_i) begin
                  state <= FR_START;
                  cnt   <= '0;
               end
            end
            FR_START: begin
               if (tick_i) begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= rx_i ? FR_IDLE : FR_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            FR_DATA: begin
               if (tick_i) begin
                  if (cnt == FULL) begin
                     cnt   <= '0;
                     shreg <= {rx_i, shreg[DATA_W-1:1]};
                     if (idx == LAST) state <= FR_STOP;
                     else             idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            FR_STOP: begin
               if (tick_i) begin
                  if (cnt == FULL) begin
                     cnt    <= '0;
                     done_o <= 1'b1;
                     stop_o <= rx_i;
                     state  <= FR_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= FR_IDLE;
         endcase
      end
   end

   assign busy_o = (state != FR_IDLE);
   assign data_o = shreg;
endmodule

// File: rtl/uwr_wake.sv
// Wake-up arming: falling edge raises the event, following rising edge disarms.
module uwr_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic idle_i,
   input  logic fall_i,
   input  logic rise_i,
   output logic en_o,
   output logic evt_o
);
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= 1'b0;
         seen <= 1'b0;
      end else if (!en_o) begin
         seen <= 1'b0;
         if (set_i && idle_i && !fall_i) en_o <= 1'b1;
      end else if (!seen) begin
         if (fall_i) seen <= 1'b1;
      end else if (rise_i) begin
         en_o <= 1'b0;
         seen <= 1'b0;
      end
   end

   assign evt_o = en_o & ~seen & fall_i;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              rd_i,
   input  logic              wake_set_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o,
   output logic              ferr_o,
   output logic              idle_o,
   output logic              wake_o
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("DATA_W must lie in 5..9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              line_s, line_fall, line_rise;
   logic              fr_busy, fr_done, fr_stop;
   logic [DATA_W-1:0] fr_data;
   logic              wake_en, wake_evt;
   logic [DATA_W-1:0] data_q;
   logic              irq_q, ferr_q;

   uwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(rx_i),
      .level_o(line_s), .fall_o(line_fall), .rise_o(line_rise)
   );

   uwr_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(line_s),
      .fall_i(line_fall), .hold_i(wake_en), .busy_o(fr_busy),
      .done_o(fr_done), .data_o(fr_data), .stop_o(fr_stop)
   );

   uwr_wake u_wake (
      .clk(clk), .rst_n(rst_n), .set_i(wake_set_i), .idle_i(~fr_busy),
      .fall_i(line_fall), .rise_i(line_rise), .en_o(wake_en), .evt_o(wake_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         irq_q  <= 1'b0;
         ferr_q <= 1'b0;
      end else if (fr_done) begin
         data_q <= fr_data;
         ferr_q <= ~fr_stop;
         irq_q  <= 1'b1;
      end else if (wake_evt) begin
         data_q <= '0;
         ferr_q <= 1'b0;
         irq_q  <= 1'b1;
      end else if (rd_i) begin
         irq_q  <= 1'b0;
      end
   end

   assign rd_data_o = data_q;
   assign irq_o     = irq_q;
   assign ferr_o    = ferr_q;
   assign idle_o    = ~fr_busy;
   assign wake_o    = wake_en;
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_i,
   input logic              wake_set_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              irq_o,
   input logic              ferr_o,
   input logic              idle_o,
   input logic              wake_o,
   input logic              rise,
   input logic              evt,
   input logic              done
);
   assert_byte_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq_o);
   assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !evt && !done) |=> !irq_o);
   assert_wake_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_o) |-> ($past(idle_o) && $past(wake_set_i)));
   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && !wake_o) |=> !wake_o);
   assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> idle_o);
   assert_wake_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (irq_o && rd_data_o == '0 && !ferr_o));
   assert_wake_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_o) |-> $past(rise));
endmodule

bind uart_wake_rx uwr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wake_set_i(wake_set_i),
   .rd_data_o(rd_data_o), .irq_o(irq_o), .ferr_o(ferr_o), .idle_o(idle_o),
   .wake_o(wake_o), .rise(line_rise), .evt(wake_evt), .done(fr_done)
);

// File: tb/sim_uart_wake_rx.sv
module sim_uart_wake_rx;
   logic       clk = 1'b0;
   logic       rst_n, rx, tick, rd, wset;
   logic [7:0] rdata;
   logic       irq, ferr, idle, wake;
   int         n_chk = 0;
   int         n_err = 0;
   bit         mon_on = 1'b1;

   typedef struct { logic [7:0] d; logic fe; } item_t;
   item_t exp_q[$];

   always #5 clk = ~clk;

   uart_wake_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .rd_i(rd),
      .wake_set_i(wset), .rd_data_o(rdata), .irq_o(irq), .ferr_o(ferr),
      .idle_o(idle), .wake_o(wake)
   );

   initial begin
      tick = 1'b0;
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic bit_time();
      repeat (32) @(negedge clk);
   endtask

   // Driver: pushes the expected byte, then drives one frame (bit = 32 cycles).
   task automatic send(input logic [7:0] b, input logic stopv, input bit probe);
      item_t it;
      it.d  = b;
      it.fe = ~stopv;
      exp_q.push_back(it);
      rx = 1'b0;
      bit_time();
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         if (probe && i == 3) begin
            repeat (16) @(negedge clk);
            check("R5 idle low mid-frame", idle, 0);
            wset = 1'b1;
            @(negedge clk);
            wset = 1'b0;
            @(negedge clk);
            check("R6 wake-set ignored while busy", wake, 0);
            repeat (14) @(negedge clk);
         end else begin
            bit_time();
         end
      end
      rx = stopv;
      bit_time();
      rx = 1'b1;
      bit_time();
   endtask

   // Monitor: pops expected items when the interrupt appears and reads the register.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && mon_on && irq === 1'b1) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected byte", rdata, 32'hFFFF_FFFF);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               check("R2 byte value", rdata, e.d);
               check("R3 framing flag", ferr, e.fe);
            end
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
            check("R4 read clears irq", irq, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      rst_n = 1'b0; rx = 1'b1; rd = 1'b0; wset = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq", irq, 0);
      check("R1 idle", idle, 1);
      check("R1 wake", wake, 0);
      check("R1 data", rdata, 0);
      check("R1 ferr", ferr, 0);

      send(8'h55, 1'b1, 1'b0);
      send(8'hA3, 1'b1, 1'b1);
      send(8'h00, 1'b1, 1'b0);
      send(8'hFF, 1'b1, 1'b0);
      send(8'h5A, 1'b0, 1'b0);   // R3 low stop bit

      // R10 short glitch
      rx = 1'b0;
      repeat (4) @(negedge clk);
      rx = 1'b1;
      repeat (40) @(negedge clk);
      check("R10 glitch gives no irq", irq, 0);
      check("R10 idle after glitch", idle, 1);

      // Wake-up sequence
      mon_on = 1'b0;
      wset = 1'b1;
      @(negedge clk);
      wset = 1'b0;
      @(negedge clk);
      check("R6 wake armed", wake, 1);
      check("R6 no irq on arm", irq, 0);
      rx = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 irq on falling edge", irq, 1);
      check("R8 dummy data", rdata, 0);
      check("R8 ferr cleared", ferr, 0);
      check("R7 wake still set", wake, 1);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      check("R4 read clears wake irq", irq, 0);
      repeat (12 * 32) @(negedge clk);
      check("R7 no irq during break", irq, 0);
      check("R7 idle during break", idle, 1);
      check("R7 wake held during break", wake, 1);
      rx = 1'b1;
      repeat (6) @(negedge clk);
      check("R9 wake cleared on rise", wake, 0);
      check("R9 no irq on rise", irq, 0);
      mon_on = 1'b1;
      send(8'h3C, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check("R9 all bytes received", exp_q.size(), 0);
      summary();
   end
endmodule